// File: doc/BRIEF.md
# Pointer-Addressed Buffer Memory Port

This block lets a byte-wide host reach a 2048 x 8 buffer memory through a window of three registers: a pointer-low byte, a pointer-high byte and a data byte. The host loads an 11-bit address through the two pointer registers. It then moves bytes through the data register. Each host access takes a single cycle and is never stretched. This works because reads are served from data that was fetched from the memory in advance, and writes are parked in the data register before they reach the memory.

The pointer-high byte also holds two control bits. One sets the transfer direction, which decides whether loading the pointer triggers a fetch. The other turns on auto-increment. With auto-increment on, the host can fill or drain a buffer in sequence without touching the pointer again. With auto-increment off, the pointer stays where it is, which suits random access. The memory is synchronous and single-ported. A one-cycle busy flag marks every fetch or commit in progress, and the host waits for it to clear before its next data-register access.

Top module: `bufram_port`

## Requirements
- R1: After reset, all four register selects read 0x00 and busy_o is low.
- R2: Register selects: 0 = data, 1 = pointer-low, 2 = pointer-high. The pointer-high byte is laid out as follows: bit 7 = read direction, bit 6 = auto-increment, bits 2:0 = pointer bits 10:8. Writing pointer-high stores the byte but does not move the pointer. Writing pointer-low sets the pointer to {stored bits 2:0, written byte}. Pointer-low reads back pointer bits 7:0. Pointer-high reads back the stored bits 7:3 together with live pointer bits 10:8.
- R3: A pointer-low write while the read direction bit is 1 raises busy_o in the next cycle. The addressed byte reads from the data register two cycles after the write.
- R4: A pointer-low write while the read direction bit is 0 leaves busy_o low.
- R5: A data-register write shows the byte on the data select in the next cycle, with busy_o high for that one cycle. The byte is committed to the memory at the pointer address.
- R6: With auto-increment off, a data-register read leaves the pointer and the data register unchanged.
- R7: With auto-increment on, a data-register read returns the held byte. The pointer is one higher in the next cycle, with busy_o high, and the byte at the new address is readable one cycle after that.
- R8: With auto-increment on, a data-register write commits at the current address. The pointer advances one cycle later, so it reads one higher two cycles after the write.
- R9: The pointer wraps from 0x7FF to 0x000 on an advance.
- R10: Data-register reads and writes made while busy_o is high have no effect on the pointer, the data register or the memory.
- R11: Select 3 always reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Host access strobe, one cycle per access |
| we_i | input | 1 | 1 = write access, 0 = read access |
| sel_i | input | 2 | Register select |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Selected register, combinational from sel_i |
| busy_o | output | 1 | Fetch or commit in progress this cycle |

## Verification
The bench counts the cycles after each access before it checks a result. Register readback is due in the same cycle as the access. A pointer change from a pointer write or a read advance is due one cycle later. busy_o is due one cycle after the access that starts a fetch or commit. Fetched data is due two cycles later, and the pointer advance after a write commit is also due two cycles later. The bench drives every access at the falling edge and samples 1 ns afterwards. Each check therefore lands in a known cycle, and the bench inserts explicit idle cycles to reach each result's due cycle. It also checks busy_o in the intermediate cycle, so a result arriving one cycle early or late is caught.

// File: rtl/bufram_pkg.sv
package bufram_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_PLO  = 2'd1,
    SEL_PHI  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam int unsigned HI_DIR_BIT  = 7;
  localparam int unsigned HI_AINC_BIT = 6;
endpackage

// File: rtl/bufram_mem.sv
module bufram_mem #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;

  // R5: single port, never read and write together
  a_r5_single_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));
endmodule

// File: rtl/bufram_ptr.sv
module bufram_ptr
  import bufram_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lo_we_i,
  input  logic          hi_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o,
  output logic [DW-1:0] hi_rd_o,
  output logic          dir_rd_o,
  output logic          ainc_o
);
  localparam int unsigned HW = AW - DW;

  logic [AW-1:0] ptr_q;
  logic [DW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      hi_q  <= '0;
    end else begin
      if (hi_we_i) hi_q <= wdata_i;
      if (lo_we_i)     ptr_q <= {hi_q[HW-1:0], wdata_i};
      else if (adv_i)  ptr_q <= ptr_q + 1'b1;  // natural wrap at top
    end
  end

  assign ptr_o    = ptr_q;
  assign hi_rd_o  = {hi_q[DW-1:HW], ptr_q[AW-1:DW]};
  assign dir_rd_o = hi_q[HI_DIR_BIT];
  assign ainc_o   = hi_q[HI_AINC_BIT];

  // R2: staging the high byte alone never moves the pointer
  a_r2_hi_staged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_we_i && !adv_i && !lo_we_i) |=> (ptr_q == $past(ptr_q)));
endmodule

// File: rtl/bufram_port.sv
module bufram_port
  import bufram_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o
);
  sel_e          sel;
  logic          acc_wr, acc_rd, lo_we, hi_we, dat_rd, dat_wr, adv;
  logic          fetch_q, commit_q, dsrc_ram_q, busy;
  logic          dir_rd, ainc;
  logic [AW-1:0] ptr;
  logic [DW-1:0] hi_rd, data_q, ram_rdata;

  assign sel    = sel_e'(sel_i);
  assign busy   = fetch_q | commit_q;
  assign acc_wr = acc_i & we_i;
  assign acc_rd = acc_i & ~we_i;
  assign lo_we  = acc_wr && (sel == SEL_PLO);
  assign hi_we  = acc_wr && (sel == SEL_PHI);
  // data-register side effects are dropped while a memory op is in flight
  assign dat_wr = acc_wr && (sel == SEL_DATA) && !busy;
  assign dat_rd = acc_rd && (sel == SEL_DATA) && !busy;
  assign adv    = ainc & (dat_rd | commit_q);

  bufram_ptr #(.AW(AW), .DW(DW)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lo_we_i  (lo_we),
    .hi_we_i  (hi_we),
    .wdata_i  (wdata_i),
    .adv_i    (adv),
    .ptr_o    (ptr),
    .hi_rd_o  (hi_rd),
    .dir_rd_o (dir_rd),
    .ainc_o   (ainc)
  );

  bufram_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (commit_q),
    .re_i    (fetch_q),
    .addr_i  (ptr),
    .wdata_i (data_q),
    .rdata_o (ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q    <= 1'b0;
      commit_q   <= 1'b0;
      dsrc_ram_q <= 1'b0;
      data_q     <= '0;
    end else begin
      fetch_q  <= (lo_we & dir_rd) | (dat_rd & ainc);
      commit_q <= dat_wr;
      if (dat_wr) begin
        data_q     <= wdata_i;
        dsrc_ram_q <= 1'b0;
      end else if (fetch_q) begin
        dsrc_ram_q <= 1'b1;  // memory output register now holds the fetched byte
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata_o = dsrc_ram_q ? ram_rdata : data_q;
      SEL_PLO:  rdata_o = ptr[DW-1:0];
      SEL_PHI:  rdata_o = hi_rd;
      default:  rdata_o = '0;
    endcase
  end

  assign busy_o = busy;

  // R3: read-direction pointer load starts a fetch next cycle
  a_r3_prefetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && we_i && sel_i == 2'd1 && dir_rd) |=> busy_o);
  // R4: write-direction pointer load starts nothing
  a_r4_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && we_i && sel_i == 2'd1 && !dir_rd) |=> !busy_o);
  // R7, R9: auto-increment read steps the pointer by one, wrapping
  a_r7_adv_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !we_i && sel_i == 2'd0 && !busy_o && ainc)
      |=> (ptr == $past(ptr) + 1'b1) && busy_o);
  // R6: fixed pointer holds across data reads
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !we_i && sel_i == 2'd0 && !busy_o && !ainc) |=> $stable(ptr) && !busy_o);
  // R10: data access during busy starts no new memory op
  a_r10_busy_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && sel_i == 2'd0 && busy_o) |=> !busy_o);
endmodule

// File: tb/bufram_port_tb.sv
`timescale 1ns/1ps
module bufram_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc = 1'b0, we = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata;
  logic       busy;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  bufram_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .we_i(we),
    .sel_i(sel), .wdata_i(wd), .rdata_o(rdata), .busy_o(busy)
  );

  // {acc, we, sel[1:0], wdata[7:0], chk, exp[7:0]}
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1,1'b1,2'd2,8'h41,1'b0,8'h00},  // ainc on, write dir, hi=1
    {1'b1,1'b1,2'd1,8'h10,1'b0,8'h00},  // ptr 0x110
    {1'b0,1'b0,2'd1,8'h00,1'b1,8'h10},
    {1'b1,1'b1,2'd0,8'hA5,1'b0,8'h00},  // commit 0x110
    {1'b0,1'b0,2'd2,8'h00,1'b1,8'h41},  // not advanced yet
    {1'b0,1'b0,2'd1,8'h00,1'b1,8'h11},  // advanced
    {1'b1,1'b1,2'd0,8'h5A,1'b0,8'h00},  // commit 0x111
    {1'b0,1'b0,2'd0,8'h00,1'b1,8'h5A},
    {1'b1,1'b1,2'd2,8'hC1,1'b0,8'h00},  // read dir, ainc
    {1'b1,1'b1,2'd1,8'h10,1'b0,8'h00},  // fetch 0x110
    {1'b0,1'b0,2'd0,8'h00,1'b0,8'h00},
    {1'b1,1'b0,2'd0,8'h00,1'b1,8'hA5},
    {1'b0,1'b0,2'd1,8'h00,1'b1,8'h11},
    {1'b1,1'b0,2'd0,8'h00,1'b1,8'h5A},
    {1'b0,1'b0,2'd1,8'h00,1'b1,8'h12},
    {1'b0,1'b0,2'd0,8'h00,1'b0,8'h00}
  };

  task automatic drive(input logic a, input logic w, input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    acc = a; we = w; sel = s; wd = d;
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] s, output logic [7:0] v);
    sel = s; #0.5; v = rdata;
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    drive(0, 0, 2'd0, 8'h00);
    chk("R1 data", rdata, 8'h00);
    chk("R1 busy", {7'd0, busy}, 8'h00);
    peek(2'd1, v); chk("R1 plo", v, 8'h00);
    peek(2'd2, v); chk("R1 phi", v, 8'h00);
    peek(2'd3, v); chk("R1 sel3", v, 8'h00);

    // table: R2 R5 R7 R8 sequential fill and drain
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][20], VEC[i][19], VEC[i][18:17], VEC[i][16:9]);
      if (VEC[i][8]) begin
        n_chk++;
        if (rdata !== VEC[i][7:0]) begin
          n_fail++;
          $display("FAIL vec %0d (R2 R5 R7 R8): actual %02h expected %02h", i, rdata, VEC[i][7:0]);
        end
      end
    end

    // R11 unused select
    drive(1, 1, 2'd3, 8'hFF);
    drive(0, 0, 2'd3, 8'h00);
    chk("R11 sel3", rdata, 8'h00);
    peek(2'd1, v); chk("R11 plo", v, 8'h12);
    peek(2'd2, v); chk("R11 phi", v, 8'hC1);

    // R4 write-direction load, R2 staging
    drive(1, 1, 2'd2, 8'h02);
    drive(0, 0, 2'd1, 8'h00);
    chk("R2 hi staged", rdata, 8'h12);
    drive(1, 1, 2'd1, 8'h05);
    drive(0, 0, 2'd0, 8'h00);
    chk("R4 busy", {7'd0, busy}, 8'h00);
    peek(2'd1, v); chk("R2 plo", v, 8'h05);
    peek(2'd2, v); chk("R2 phi", v, 8'h02);

    // R5 write, no ainc
    drive(1, 1, 2'd0, 8'h3C);
    drive(0, 0, 2'd0, 8'h00);
    chk("R5 busy", {7'd0, busy}, 8'h01);
    chk("R5 data", rdata, 8'h3C);
    peek(2'd1, v); chk("R5 plo", v, 8'h05);

    // R3 prefetch, R6 fixed pointer read
    drive(1, 1, 2'd2, 8'h82);
    drive(1, 1, 2'd1, 8'h05);
    drive(0, 0, 2'd0, 8'h00);
    chk("R3 busy", {7'd0, busy}, 8'h01);
    drive(0, 0, 2'd0, 8'h00);
    chk("R3 idle", {7'd0, busy}, 8'h00);
    chk("R3 data", rdata, 8'h3C);
    drive(1, 0, 2'd0, 8'h00);
    chk("R6 read", rdata, 8'h3C);
    drive(0, 0, 2'd1, 8'h00);
    chk("R6 plo", rdata, 8'h05);
    chk("R6 busy", {7'd0, busy}, 8'h00);
    peek(2'd0, v); chk("R6 data", v, 8'h3C);

    // R10 data access while busy
    drive(1, 1, 2'd2, 8'hC2);
    drive(1, 1, 2'd1, 8'h05);
    drive(1, 0, 2'd0, 8'h00);
    drive(0, 0, 2'd1, 8'h00);
    chk("R10 rd plo", rdata, 8'h05);
    chk("R10 rd busy", {7'd0, busy}, 8'h00);
    drive(1, 1, 2'd1, 8'h05);
    drive(1, 1, 2'd0, 8'h77);
    drive(0, 0, 2'd0, 8'h00);
    chk("R10 wr data", rdata, 8'h3C);
    chk("R10 wr busy", {7'd0, busy}, 8'h00);

    // R8 advance after commit, R9 wrap
    drive(1, 1, 2'd2, 8'h47);
    drive(1, 1, 2'd1, 8'hFF);
    drive(1, 1, 2'd0, 8'h99);
    drive(0, 0, 2'd1, 8'h00);
    chk("R8 plo held", rdata, 8'hFF);
    chk("R8 busy", {7'd0, busy}, 8'h01);
    drive(0, 0, 2'd1, 8'h00);
    chk("R9 plo wrap", rdata, 8'h00);
    peek(2'd2, v); chk("R9 phi wrap", v, 8'h40);
    drive(1, 1, 2'd0, 8'h66);
    drive(0, 0, 2'd0, 8'h00);

    // R7 read advance across wrap
    drive(1, 1, 2'd2, 8'hC7);
    drive(1, 1, 2'd1, 8'hFF);
    drive(0, 0, 2'd0, 8'h00);
    drive(1, 0, 2'd0, 8'h00);
    chk("R9 read top", rdata, 8'h99);
    drive(0, 0, 2'd1, 8'h00);
    chk("R7 plo", rdata, 8'h00);
    chk("R7 busy", {7'd0, busy}, 8'h01);
    drive(0, 0, 2'd0, 8'h00);
    chk("R7 next byte", rdata, 8'h66);

    drive(0, 0, 2'd0, 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule